// File: doc/BRIEF.md
# Linked-Page DMA Ring Fill Engine

This block is a bus-master writer that moves an incoming word stream into a ring of fixed-size memory pages. Software builds the ring in memory as a chain of descriptor pages. Word 0 of each descriptor page holds the page number of the next descriptor page. The remaining slots hold the page numbers of the data pages, to be filled in order. A page number is a byte address shifted right by 12. The engine fills one data page at a time. When every other word of the page is written, it writes a non-zero completion marker into the second-to-last word of that page. Software polls that marker and clears it once it has consumed the page.

Flow control uses credits. Each credit lets the engine enter one descriptor page. Software clears the credit counter, grants a credit per descriptor page it has freed (a full ring's worth at start-up), loads the first descriptor page number into a base register and issues a start command. A stop command ends the transfer at a clean point, and a busy bit shows when the engine has finished. Memory is reached through a single word request port with a combined grant/read-valid handshake.

Top module: `page_ring_dma`

## Requirements
- R1: After reset the engine is idle. The status word reads zero, no memory request is raised and `in_ready` is low.
- R2: On start, the engine reads word 0 of the current descriptor page (the link) and then descriptor slot 1. A read request holds its address until `mem_ack`.
- R3: Each data page receives `PAGE_WORDS-1` stream words at ascending word indices, skipping index `PAGE_WORDS-2`. After the last of these, `MARK_VAL` is written at index `PAGE_WORDS-2`.
- R4: Slots 1 to `DATA_SLOTS` of a descriptor page are used in order. After the last slot the engine moves to the page named by the link word, so the ring wraps wherever the link points.
- R5: Entering a descriptor page consumes one credit. Control value 0x00000010 clears the counter and 0x00000020 adds one. With no credit, the engine issues no memory request and holds `in_ready` low.
- R6: The credit counter saturates at `RING_LEN`. A credit add at that limit is dropped and sets status bit 1 (counter error).
- R7: Stream data offered while the engine waits with zero credits sets status bit 0 (overflow).
- R8: A start command while busy is ignored and sets status bit 2 (warning).
- R9: Control value 0x08080000 requests a stop. Status bit 6 (busy) falls at the next completion marker, in a credit wait, or before the first word of a page, and no memory request follows.
- R10: Control writes of any other value have no effect.
- R11: Status bits 0 to 2 are sticky until a credit-counter clear, which zeroes them.
- R12: Register address 1 holds the start page number and reads back what was written. Address 0 reads status. Start (0x0c000040) copies the start page number into the current descriptor pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0: control/status, 1: start page number |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| in_valid | input | 1 | Stream word valid |
| in_data | input | DW | Stream word |
| in_ready | output | 1 | Stream word accepted this cycle |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | PN_W+log2(PAGE_WORDS) | Word address {page, index} |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Request granted; read data valid |
| mem_rdata | input | DW | Read data |

## Verification
The assertions assume that memory acknowledges each request eventually and returns read data in the same cycle as `mem_ack`. They also assume the stream keeps a word stable while `in_valid` is high and `in_ready` is low, and that the link and slot words contain page numbers that fit `PN_W`. The bench models memory as a word array that answers reads combinationally. It grants on a fixed two-in-three pattern, so requests are sometimes held. The stream driver keeps each word steady until it is accepted. The descriptor words are laid out before reset and are never changed while the engine runs.

// File: rtl/page_ring_dma.sv
module page_ring_dma #(
  parameter int DW         = 32,
  parameter int PN_W       = 20,
  parameter int PAGE_WORDS = 1024,
  parameter int DATA_SLOTS = 511,
  parameter int RING_LEN   = 64,
  parameter logic [DW-1:0] MARK_VAL = 32'h0000_0001
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               reg_wr,
  input  logic                               reg_addr,
  input  logic [DW-1:0]                      reg_wdata,
  output logic [DW-1:0]                      reg_rdata,
  input  logic                               in_valid,
  input  logic [DW-1:0]                      in_data,
  output logic                               in_ready,
  output logic                               mem_req,
  output logic                               mem_we,
  output logic [PN_W+$clog2(PAGE_WORDS)-1:0] mem_addr,
  output logic [DW-1:0]                      mem_wdata,
  input  logic                               mem_ack,
  input  logic [DW-1:0]                      mem_rdata
);
  localparam int IDX_W    = $clog2(PAGE_WORDS);
  localparam int SLOT_W   = $clog2(DATA_SLOTS + 1);
  localparam int CRED_W   = $clog2(RING_LEN + 1);
  localparam int MARK_IDX = PAGE_WORDS - 2;
  localparam logic [DW-1:0] CMD_CLR  = 32'h0000_0010;
  localparam logic [DW-1:0] CMD_ADD  = 32'h0000_0020;
  localparam logic [DW-1:0] CMD_GO   = 32'h0c00_0040;
  localparam logic [DW-1:0] CMD_HALT = 32'h0808_0000;

  typedef enum logic [2:0] {S_IDLE, S_CREDIT, S_LINK, S_SLOT, S_FILL, S_MARK} st_t;
  st_t state;

  logic [PN_W-1:0]   base_pg, cur_pg, nxt_pg, dat_pg;
  logic [SLOT_W-1:0] slot;
  logic [IDX_W-1:0]  widx;
  logic [CRED_W-1:0] credits;
  logic st_ovf, st_cerr, st_warn, stop_pend;

  wire ctrl_wr   = reg_wr && !reg_addr;
  wire cmd_clr   = ctrl_wr && reg_wdata == CMD_CLR;
  wire cmd_add   = ctrl_wr && reg_wdata == CMD_ADD;
  wire cmd_go    = ctrl_wr && reg_wdata == CMD_GO;
  wire cmd_halt  = ctrl_wr && reg_wdata == CMD_HALT;
  wire busy      = state != S_IDLE;
  wire at_max    = credits == CRED_W'(RING_LEN);
  wire take      = state == S_CREDIT && !stop_pend && credits != '0;
  wire fill_quit = state == S_FILL && stop_pend && widx == '0;
  wire fill_act  = state == S_FILL && !fill_quit;
  wire last_w    = widx == IDX_W'(PAGE_WORDS - 1);
  wire last_slot = slot == SLOT_W'(DATA_SLOTS);

  assign in_ready  = fill_act && mem_ack;
  assign mem_req   = (state == S_LINK) || (state == S_SLOT) || (state == S_MARK) || (fill_act && in_valid);
  assign mem_we    = (state == S_FILL) || (state == S_MARK);
  assign mem_wdata = (state == S_MARK) ? MARK_VAL : in_data;

  always_comb begin
    case (state)
      S_LINK:  mem_addr = {cur_pg, IDX_W'(0)};
      S_SLOT:  mem_addr = {cur_pg, IDX_W'(slot)};
      S_MARK:  mem_addr = {dat_pg, IDX_W'(MARK_IDX)};
      default: mem_addr = {dat_pg, widx};
    endcase
  end

  assign reg_rdata = reg_addr ? {{(DW-PN_W){1'b0}}, base_pg}
                              : {{(DW-7){1'b0}}, busy, 3'b000, st_warn, st_cerr, st_ovf};

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      base_pg <= '0; cur_pg <= '0; nxt_pg <= '0; dat_pg <= '0;
      slot <= '0; widx <= '0; credits <= '0;
      st_ovf <= 1'b0; st_cerr <= 1'b0; st_warn <= 1'b0; stop_pend <= 1'b0;
    end else begin
      if (reg_wr && reg_addr) base_pg <= reg_wdata[PN_W-1:0];

      if (cmd_clr) credits <= '0;
      else credits <= credits + CRED_W'(cmd_add && !at_max) - CRED_W'(take);

      if (cmd_clr) begin
        st_ovf <= 1'b0; st_cerr <= 1'b0; st_warn <= 1'b0;
      end else begin
        if (state == S_CREDIT && credits == '0 && in_valid) st_ovf <= 1'b1;
        if (cmd_add && at_max) st_cerr <= 1'b1;
        if (cmd_go && busy) st_warn <= 1'b1;
      end

      if (cmd_halt && busy) stop_pend <= 1'b1;

      case (state)
        S_IDLE: begin
          stop_pend <= 1'b0;
          if (cmd_go) begin
            cur_pg <= base_pg;
            state  <= S_CREDIT;
          end
        end
        S_CREDIT: begin
          if (stop_pend) state <= S_IDLE;
          else if (take) begin
            slot  <= SLOT_W'(1);
            state <= S_LINK;
          end
        end
        S_LINK: if (mem_ack) begin
          nxt_pg <= mem_rdata[PN_W-1:0];
          state  <= S_SLOT;
        end
        S_SLOT: if (mem_ack) begin
          dat_pg <= mem_rdata[PN_W-1:0];
          widx   <= '0;
          state  <= S_FILL;
        end
        S_FILL: begin
          if (fill_quit) state <= S_IDLE;
          else if (in_valid && mem_ack) begin
            if (last_w) state <= S_MARK;
            else widx <= (widx == IDX_W'(MARK_IDX - 1)) ? IDX_W'(MARK_IDX + 1) : widx + 1'b1;
          end
        end
        S_MARK: if (mem_ack) begin
          if (stop_pend) state <= S_IDLE;
          else if (last_slot) begin
            cur_pg <= nxt_pg;
            state  <= S_CREDIT;
          end else begin
            slot  <= slot + 1'b1;
            state <= S_SLOT;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [IDX_W:0] pg_wr;
  always_ff @(posedge clk) begin
    if (rst || state == S_SLOT) pg_wr <= '0;
    else if (in_valid && in_ready) pg_wr <= pg_wr + 1'b1;
  end

  assert_mark_last_R3: assert property (@(posedge clk) disable iff (rst)
    (state == S_MARK && mem_ack) |-> pg_wr == (IDX_W+1)'(PAGE_WORDS - 1));

  assert_read_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  assert_credit_use_R5: assert property (@(posedge clk) disable iff (rst)
    (credits < $past(credits) && !$past(cmd_clr)) |-> $past(state) == S_CREDIT);

  assert_credit_cap_R6: assert property (@(posedge clk) disable iff (rst)
    credits <= CRED_W'(RING_LEN));

  assert_stop_end_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(stop_pend));

  assert_sticky_ovf_R11: assert property (@(posedge clk) disable iff (rst)
    ($past(st_ovf) && !$past(cmd_clr)) |-> st_ovf);
endmodule

// File: tb/page_ring_dma_tb.sv
`timescale 1ns/1ps
module page_ring_dma_tb_top;
  localparam int PW = 8, SL = 3, RL = 2, PNW = 8, AW = PNW + 3;
  localparam logic [31:0] MARK = 32'h0000_0001;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 1'b0, reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0, in_data = '0;
  logic in_valid = 1'b0;
  logic [31:0] reg_rdata, mem_wdata, mem_rdata;
  logic in_ready, mem_req, mem_we, mem_ack, ack_en = 1'b1;
  logic [AW-1:0] mem_addr;

  logic [31:0] tmem [0:(1<<AW)-1];
  logic [AW-1:0] wlog_a [0:1023];
  logic [31:0]   wlog_d [0:1023];
  logic [AW-1:0] rlog_a [0:255];
  int wcount = 0, rcount = 0, cyc = 0, checks = 0, errors = 0;
  logic [31:0] seq = 32'h100;

  always #2 clk = ~clk;

  page_ring_dma #(.PN_W(PNW), .PAGE_WORDS(PW), .DATA_SLOTS(SL), .RING_LEN(RL), .MARK_VAL(MARK)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  assign mem_ack   = mem_req && ack_en;
  assign mem_rdata = tmem[mem_addr];

  always @(negedge clk) begin
    cyc <= cyc + 1;
    ack_en = (cyc % 3) != 2;
  end

  always @(posedge clk) begin
    if (mem_req && mem_ack) begin
      if (mem_we) begin
        tmem[mem_addr] <= mem_wdata;
        wlog_a[wcount] <= mem_addr; wlog_d[wcount] <= mem_wdata; wcount <= wcount + 1;
      end else begin
        rlog_a[rcount] <= mem_addr; rcount <= rcount + 1;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wreg(logic a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_addr = 1'b0;
  endtask

  task automatic rreg(logic a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic send_word();
    @(negedge clk); in_valid = 1'b1; in_data = seq;
    forever begin
      #1;
      if (in_ready) begin @(posedge clk); break; end
      @(negedge clk);
    end
    seq++;
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_page(int first, logic [PNW-1:0] pg, logic [31:0] d0, string tag);
    for (int j = 0; j < PW; j++) begin
      int k = first + j;
      if (j < PW - 1) begin
        int ix = (j < PW - 2) ? j : PW - 1;
        chk({tag, " payload address"}, 32'(wlog_a[k]), 32'(pg) * PW + ix);
        chk({tag, " payload data"}, wlog_d[k], d0 + j);
      end else begin
        chk({tag, " marker address"}, 32'(wlog_a[k]), 32'(pg) * PW + PW - 2);
        chk({tag, " marker value"}, wlog_d[k], MARK);
      end
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rreg(1'b0, v);
    chk("R1 status after reset", v, 32'h0);
    chk("R1 mem_req idle", 32'(mem_req), 0);
    chk("R1 in_ready idle", 32'(in_ready), 0);
  endtask

  task automatic t_config();
    logic [31:0] v;
    wreg(1'b1, 32'h1);
    rreg(1'b1, v);
    chk("R12 base readback", v, 32'h1);
    wreg(1'b0, 32'h0000_1234);
    idle(5);
    rreg(1'b0, v);
    chk("R10 unknown control ignored", v, 32'h0);
  endtask

  task automatic t_no_credit();
    logic [31:0] v;
    wreg(1'b0, 32'h10);
    wreg(1'b0, 32'h0c00_0040);
    idle(10);
    chk("R5 no reads without credit", rcount, 0);
    @(negedge clk); in_valid = 1'b1; in_data = 32'hdead;
    idle(3);
    in_valid = 1'b0;
    chk("R5 no writes without credit", wcount, 0);
    rreg(1'b0, v);
    chk("R7 overflow bit", v, 32'h41);
    wreg(1'b0, 32'h0c00_0040);
    rreg(1'b0, v);
    chk("R8 start while busy warns", v, 32'h45);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wreg(1'b0, 32'h10);
    rreg(1'b0, v);
    chk("R11 clear zeroes sticky bits", v, 32'h40);
    wreg(1'b0, 32'h30);
    idle(10);
    chk("R10 other value adds no credit", rcount, 0);
  endtask

  task automatic t_first_desc();
    wreg(1'b0, 32'h20);
    for (int n = 0; n < SL * (PW - 1); n++) send_word();
    for (int i = 0; i < 200 && wcount < SL * PW; i++) @(negedge clk);
    chk("R2 link read address", 32'(rlog_a[0]), 1 * PW + 0);
    chk("R2 slot 1 read address", 32'(rlog_a[1]), 1 * PW + 1);
    chk("R4 slot 2 read address", 32'(rlog_a[2]), 1 * PW + 2);
    chk("R4 slot 3 read address", 32'(rlog_a[3]), 1 * PW + 3);
    check_page(0, 8'd10, 32'h100, "R3 page10");
    check_page(PW, 8'd11, 32'h100 + PW - 1, "R3 page11");
    check_page(2 * PW, 8'd12, 32'h100 + 2 * (PW - 1), "R4 page12");
    idle(10);
    chk("R5 waits for credit after descriptor", rcount, 4);
  endtask

  task automatic t_stop_mid();
    logic [31:0] v;
    wreg(1'b0, 32'h20);
    for (int n = 0; n < 3; n++) send_word();
    wreg(1'b0, 32'h0808_0000);
    rreg(1'b0, v);
    chk("R9 busy while page open", v & 32'h40, 32'h40);
    for (int n = 0; n < PW - 4; n++) send_word();
    for (int i = 0; i < 50 && dut_busy(); i++) @(negedge clk);
    rreg(1'b0, v);
    chk("R9 busy clear after marker", v, 32'h0);
    chk("R4 link followed to page 2", 32'(rlog_a[4]), 2 * PW + 0);
    chk("R9 marker on stopped page", tmem[20 * PW + PW - 2], MARK);
    idle(10);
    chk("R9 no reads after stop", rcount, 6);
    chk("R9 no writes after stop", wcount, SL * PW + PW);
  endtask

  function automatic logic dut_busy();
    return reg_rdata[6];
  endfunction

  task automatic t_wrap();
    logic [31:0] v;
    wreg(1'b1, 32'h2);
    wreg(1'b0, 32'h10);
    wreg(1'b0, 32'h20);
    wreg(1'b0, 32'h20);
    wreg(1'b0, 32'h0c00_0040);
    for (int n = 0; n < SL * (PW - 1); n++) send_word();
    for (int i = 0; i < 100 && rcount < 12; i++) @(negedge clk);
    chk("R4 wrap link read", 32'(rlog_a[10]), 1 * PW + 0);
    chk("R4 wrap slot read", 32'(rlog_a[11]), 1 * PW + 1);
    check_page(SL * PW + PW + 2 * PW, 8'd22, 32'h100 + (SL + 1) * (PW - 1) + 2 * (PW - 1), "R3 page22");
    wreg(1'b0, 32'h0808_0000);
    idle(5);
    rreg(1'b0, v);
    chk("R9 stop before first word", v, 32'h0);
    chk("R9 no payload after stop", wcount, 2 * SL * PW + PW);
  endtask

  task automatic t_saturate();
    logic [31:0] v;
    wreg(1'b0, 32'h10);
    wreg(1'b0, 32'h20);
    wreg(1'b0, 32'h20);
    rreg(1'b0, v);
    chk("R6 no error at limit", v, 32'h0);
    wreg(1'b0, 32'h20);
    rreg(1'b0, v);
    chk("R6 error past limit", v, 32'h2);
    wreg(1'b0, 32'h10);
    rreg(1'b0, v);
    chk("R11 clear after error", v, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) tmem[i] = '0;
    tmem[1 * PW + 0] = 2; tmem[1 * PW + 1] = 10; tmem[1 * PW + 2] = 11; tmem[1 * PW + 3] = 12;
    tmem[2 * PW + 0] = 1; tmem[2 * PW + 1] = 20; tmem[2 * PW + 2] = 21; tmem[2 * PW + 3] = 22;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_config();
    t_no_credit();
    t_clear();
    t_first_desc();
    t_stop_mid();
    t_wrap();
    t_saturate();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R9 watchdog actual=%0d cycles expected=fewer", 100000);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule